// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the processor-facing side of a three-channel interval timer. A byte-wide synchronous bus with a two-bit address, a select, a read strobe and a write strobe reaches four registers. The three lower addresses are the count ports of the channels. The top address takes configuration words, which either reprogram one channel or ask it to freeze its count. The counting engines live outside this block. Each engine gives the block its live count and takes back a 16-bit start value, a one-cycle strobe marking a new start value, an operating-mode code and a decimal-count flag.

Counts move over the byte bus in halves. Each channel keeps its own write pointer and its own read pointer, which choose the half that the next access touches. A freeze command copies the live count into a per-channel holding register. Reads of that channel then return the frozen value in two steps, low half before high half, while the engine keeps counting. Once both halves have been read, the channel goes back to returning live data.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel reports mode 0, the decimal flag clear and a start value of 0. No load strobe is high and the read data is 0x00. Every channel uses two-byte transfers, with both of its pointers on the low half.
- R2: A write to address 3 is a configuration word. Bits 7:6 pick the channel, bits 5:4 the transfer kind (00 freeze, 01 low half only, 10 high half only, 11 both halves) and bits 3:1 the mode. Bit 0 is the decimal flag. A word with a nonzero transfer kind sets the mode and decimal flag of the chosen channel only.
- R3: Reprogramming a channel (a nonzero transfer kind) clears its start value to 0 in the next cycle. It also returns both of its byte pointers to the low half and drops any frozen snapshot.
- R4: In two-byte transfers, the first write to a count address fills the low half and does not strobe. The second write fills the high half. In the cycle after that second write, the load strobe for that channel is high for exactly one cycle, and the start value output shows {high, low}.
- R5: In low-only transfers, every write loads {0x00, byte} with a strobe, and every read returns bits 7:0 of the count. In high-only transfers, every write loads {byte, 0x00} with a strobe, and every read returns bits 15:8.
- R6: A freeze word (transfer kind 00) copies the chosen channel's live count. Later reads of that channel return the copy's low half and then its high half, even if the live count has changed. The channel's mode and transfer kind do not change.
- R7: A freeze word that arrives while a previous copy has not been fully read is ignored, and the older copy is kept.
- R8: After both halves of a frozen copy have been read, further reads return the live count again.
- R9: A configuration word whose channel field is 11 changes no channel's mode, flag or start value.
- R10: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. A read of address 3 returns 0x00.
- R11: Without a frozen copy, two-byte reads alternate between the low and high halves of the live count, sampled at each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 2 | Register address (0..2 count ports, 3 configuration) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| live_cnt | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| load_stb | output | 3 | One-cycle strobe per channel for a completed start value |
| load_val | output | 48 | Start value of each channel |
| ch_mode | output | 9 | Operating mode of each channel, 3 bits each |
| ch_bcd | output | 3 | Decimal-count flag of each channel |

## Verification
The properties take for granted that the bus never raises the read and write strobes together while selected. One of them checks this input rule. The stimulus performs a single access per transaction and always drops both strobes between transactions. The properties also rely on a change of mode only being caused by a configuration word for that channel. The stimulus holds the live counts steady across each access and changes them only between transactions, so that a frozen copy and a later live read give known, different values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    XFER_FREEZE = 2'b00,
    XFER_LO     = 2'b01,
    XFER_HI     = 2'b10,
    XFER_WORD   = 2'b11
  } xfer_e;

  // Configuration word, bit 7 first
  typedef struct packed {
    logic [1:0] chan;
    xfer_e      xfer;
    logic [2:0] mode;
    logic       bcd;
  } cfg_word_t;

  typedef struct packed {
    xfer_e      xfer;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tmr_cfg_dec.sv
module tmr_cfg_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              cfg_we,
  input  logic [7:0]        wdata,
  output logic [NUM_CH-1:0] prog,
  output logic [NUM_CH-1:0] freeze,
  output chan_cfg_t         cfg
);

  cfg_word_t word;

  always_comb begin
    word   = cfg_word_t'(wdata);
    cfg    = '{xfer: word.xfer, mode: word.mode, bcd: word.bcd};
    prog   = '0;
    freeze = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cfg_we && (int'(word.chan) == i)) begin
        if (word.xfer == XFER_FREEZE) freeze[i] = 1'b1;
        else                          prog[i]   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
#(
  parameter  int CW = 16,
  localparam int BW = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_i,
  input  logic          freeze_i,
  input  chan_cfg_t     cfg_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [CW-1:0] live_i,
  output logic [BW-1:0] rbyte_o,
  output logic          load_stb_o,
  output logic [CW-1:0] load_val_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);

  chan_cfg_t     cfg_q, cfg_d;
  logic [CW-1:0] start_q, start_d;
  logic [CW-1:0] snap_q, snap_d;
  logic          snap_vld_q, snap_vld_d;
  logic          wr_hi_q, wr_hi_d;
  logic          rd_hi_q, rd_hi_d;
  logic          stb_q, stb_d;
  logic [CW-1:0] src;

  assign src = snap_vld_q ? snap_q : live_i;

  always_comb begin
    unique case (cfg_q.xfer)
      XFER_LO: rbyte_o = src[BW-1:0];
      XFER_HI: rbyte_o = src[CW-1:BW];
      default: rbyte_o = rd_hi_q ? src[CW-1:BW] : src[BW-1:0];
    endcase
  end

  always_comb begin
    cfg_d      = cfg_q;
    start_d    = start_q;
    snap_d     = snap_q;
    snap_vld_d = snap_vld_q;
    wr_hi_d    = wr_hi_q;
    rd_hi_d    = rd_hi_q;
    stb_d      = 1'b0;
    if (prog_i) begin
      cfg_d      = cfg_i;
      start_d    = '0;
      snap_vld_d = 1'b0;
      wr_hi_d    = 1'b0;
      rd_hi_d    = 1'b0;
    end else begin
      if (freeze_i && !snap_vld_q) begin
        snap_d     = live_i;
        snap_vld_d = 1'b1;
      end
      if (wr_i) begin
        unique case (cfg_q.xfer)
          XFER_LO: begin
            start_d = {{BW{1'b0}}, wdata_i};
            stb_d   = 1'b1;
          end
          XFER_HI: begin
            start_d = {wdata_i, {BW{1'b0}}};
            stb_d   = 1'b1;
          end
          default: begin
            if (!wr_hi_q) begin
              start_d[BW-1:0] = wdata_i;
              wr_hi_d         = 1'b1;
            end else begin
              start_d[CW-1:BW] = wdata_i;
              wr_hi_d          = 1'b0;
              stb_d            = 1'b1;
            end
          end
        endcase
      end
      if (rd_i) begin
        if (cfg_q.xfer == XFER_WORD) begin
          rd_hi_d = !rd_hi_q;
          if (rd_hi_q) snap_vld_d = 1'b0;
        end else begin
          snap_vld_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '{xfer: XFER_WORD, mode: 3'd0, bcd: 1'b0};
      start_q    <= '0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      stb_q      <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      start_q    <= start_d;
      snap_q     <= snap_d;
      snap_vld_q <= snap_vld_d;
      wr_hi_q    <= wr_hi_d;
      rd_hi_q    <= rd_hi_d;
      stb_q      <= stb_d;
    end
  end

  assign load_stb_o = stb_q;
  assign load_val_o = start_q;
  assign mode_o     = cfg_q.mode;
  assign bcd_o      = cfg_q.bcd;

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter  int NUM_CH = 3,
  parameter  int CW     = 16,
  localparam int BW     = CW / 2,
  localparam int AW     = $clog2(NUM_CH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [BW-1:0]        bus_wdata,
  output logic [BW-1:0]        bus_rdata,
  input  logic [NUM_CH*CW-1:0] live_cnt,
  output logic [NUM_CH-1:0]    load_stb,
  output logic [NUM_CH*CW-1:0] load_val,
  output logic [NUM_CH*3-1:0]  ch_mode,
  output logic [NUM_CH-1:0]    ch_bcd
);

  localparam logic [AW-1:0] CFG_ADDR = AW'(NUM_CH);

  logic              rst_s;
  logic              rd_any, wr_any, cfg_we;
  logic [NUM_CH-1:0] prog, freeze;
  chan_cfg_t         cfg;
  logic [BW-1:0]     rbyte [NUM_CH];
  logic [BW-1:0]     rdata_q, rdata_d;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  assign rd_any = bus_sel && bus_rd;
  assign wr_any = bus_sel && bus_wr;
  assign cfg_we = wr_any && (bus_addr == CFG_ADDR);

  tmr_cfg_dec #(.NUM_CH(NUM_CH)) u_dec (
    .cfg_we (cfg_we),
    .wdata  (bus_wdata),
    .prog   (prog),
    .freeze (freeze),
    .cfg    (cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [AW-1:0] MY_ADDR = AW'(g);
    tmr_chan_port #(.CW(CW)) u_port (
      .clk        (clk),
      .rst_n      (rst_s),
      .prog_i     (prog[g]),
      .freeze_i   (freeze[g]),
      .cfg_i      (cfg),
      .wr_i       (wr_any && (bus_addr == MY_ADDR)),
      .rd_i       (rd_any && (bus_addr == MY_ADDR)),
      .wdata_i    (bus_wdata),
      .live_i     (live_cnt[g*CW +: CW]),
      .rbyte_o    (rbyte[g]),
      .load_stb_o (load_stb[g]),
      .load_val_o (load_val[g*CW +: CW]),
      .mode_o     (ch_mode[g*3 +: 3]),
      .bcd_o      (ch_bcd[g])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_any) begin
      rdata_d = '0;
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr == AW'(i)) rdata_d = rbyte[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter  int NUM_CH = 3,
  parameter  int CW     = 16,
  localparam int BW     = CW / 2,
  localparam int AW     = $clog2(NUM_CH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [AW-1:0]        bus_addr,
  input logic [BW-1:0]        bus_wdata,
  input logic [BW-1:0]        bus_rdata,
  input logic [NUM_CH-1:0]    load_stb,
  input logic [NUM_CH*CW-1:0] load_val,
  input logic [NUM_CH*3-1:0]  ch_mode
);

  logic cfg_we;
  assign cfg_we = bus_sel && bus_wr && (bus_addr == AW'(NUM_CH));

  // R10: input rule, one access kind per cycle
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd && bus_wr));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |=> $stable(bus_rdata));

  p_chan3_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bus_wdata[7:6] == 2'b11) |=> ($stable(ch_mode) && $stable(load_val)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_mode_only_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && int'(bus_wdata[7:6]) == g && bus_wdata[5:4] != 2'b00)
      |=> $stable(ch_mode[g*3 +: 3]));

    p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(bus_wdata[7:6]) == g && bus_wdata[5:4] != 2'b00)
      |=> (load_val[g*CW +: CW] == '0));

    p_stb_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[g] |-> $past(bus_sel && bus_wr && int'(bus_addr) == g));

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[g] |=> !load_stb[g]);
  end

endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .bus_sel   (bus_sel),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .load_stb  (load_stb),
  .load_val  (load_val),
  .ch_mode   (ch_mode)
);

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_rd, bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] live;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tmr_host_if u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .live_cnt  (live),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .ch_mode   (ch_mode),
    .ch_bcd    (ch_bcd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] cfg_byte(input int ch, input int xf, input int md, input int bcd);
    return {2'(ch), 2'(xf), 3'(md), 1'(bcd)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 2'(a);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live[ch*16 +: 16] = v;
  endtask

  function automatic logic [15:0] lv(input int ch);
    return load_val[ch*16 +: 16];
  endfunction

  function automatic logic [2:0] md(input int ch);
    return ch_mode[ch*3 +: 3];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, l1, l2;
    logic [8:0]  mode_before;
    logic [47:0] val_before;
    int ch, m, bc;

    rst_n = 1'b0; bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    live = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 modes", 32'(ch_mode), 32'h0);
    chk("R1 bcd", 32'(ch_bcd), 32'h0);
    chk("R1 start values", 32'(load_val[31:0]), 32'h0);
    chk("R1 start value ch2", 32'(lv(2)), 32'h0);
    chk("R1 strobes", 32'(load_stb), 32'h0);
    chk("R1 rdata", 32'(bus_rdata), 32'h0);

    // R1 R4 default two-byte write
    do_wr(0, 8'h34);
    chk("R4 no strobe after low", 32'(load_stb), 32'h0);
    do_wr(0, 8'h12);
    chk("R4 strobe after high", 32'(load_stb), 32'h1);
    chk("R1 R4 value", 32'(lv(0)), 32'h1234);
    @(negedge clk);
    chk("R4 strobe one cycle", 32'(load_stb), 32'h0);

    // R11 unlatched alternation
    set_live(1, 16'hABCD);
    do_rd(1, b); chk("R11 low live", 32'(b), 32'hCD);
    set_live(1, 16'h5678);
    do_rd(1, b); chk("R11 high live", 32'(b), 32'h56);

    // R6 R7 R8 freeze
    set_live(2, 16'h1111);
    do_wr(3, cfg_byte(2, 0, 0, 0));
    set_live(2, 16'h2222);
    do_wr(3, cfg_byte(2, 0, 0, 0));
    set_live(2, 16'h3344);
    do_rd(2, b); chk("R6 R7 frozen low", 32'(b), 32'h11);
    do_rd(2, b); chk("R6 R7 frozen high", 32'(b), 32'h11);
    do_rd(2, b); chk("R8 live low", 32'(b), 32'h44);
    do_rd(2, b); chk("R8 live high", 32'(b), 32'h33);
    chk("R6 mode kept", 32'(md(2)), 32'h0);

    // R9 channel 3 ignored
    mode_before = ch_mode; val_before = load_val;
    do_wr(3, 8'hFE);
    chk("R9 modes", 32'(ch_mode), 32'(mode_before));
    chk("R9 values", 32'(load_val[31:0]), val_before[31:0]);
    chk("R9 bcd", 32'(ch_bcd), 32'h0);

    // R3 program clears and restarts sequence
    do_wr(0, 8'h99);
    do_wr(3, cfg_byte(0, 3, 2, 0));
    chk("R3 cleared", 32'(lv(0)), 32'h0);
    chk("R2 mode ch0", 32'(md(0)), 32'h2);
    chk("R2 other channel", 32'(md(1)), 32'h0);
    do_wr(0, 8'h78);
    chk("R3 low restart no strobe", 32'(load_stb), 32'h0);
    do_wr(0, 8'h56);
    chk("R3 R4 value", 32'(lv(0)), 32'h5678);

    // R5 low-only and high-only
    set_live(1, 16'h5678);
    do_wr(3, cfg_byte(1, 1, 3, 0));
    do_wr(1, 8'hAB);
    chk("R5 low-only strobe", 32'(load_stb), 32'h2);
    chk("R5 low-only value", 32'(lv(1)), 32'h00AB);
    do_rd(1, b); chk("R5 low-only read", 32'(b), 32'h78);
    do_rd(1, b); chk("R5 low-only read again", 32'(b), 32'h78);
    do_wr(3, cfg_byte(1, 2, 4, 1));
    chk("R2 mode and bcd", 32'({ch_bcd[1], md(1)}), 32'hC);
    do_wr(1, 8'hCD);
    chk("R5 high-only value", 32'(lv(1)), 32'hCD00);
    do_rd(1, b); chk("R5 high-only read", 32'(b), 32'h56);

    // R10 config read and hold
    do_rd(3, b); chk("R10 cfg read", 32'(b), 32'h00);
    do_rd(0, b);
    repeat (3) @(negedge clk);
    chk("R10 hold", 32'(bus_rdata), 32'(b));

    // Random mix
    void'($urandom(32'd2024));
    for (int it = 0; it < 40; it++) begin
      ch = int'($urandom_range(2, 0));
      m  = int'($urandom_range(5, 0));
      bc = int'($urandom_range(1, 0));
      v  = 16'($urandom);
      do_wr(3, cfg_byte(ch, 3, m, bc));
      chk("R2 random mode", 32'({ch_bcd[ch], md(ch)}), 32'({1'(bc), 3'(m)}));
      chk("R3 random clear", 32'(lv(ch)), 32'h0);
      do_wr(ch, v[7:0]);
      chk("R4 random low", 32'({load_stb, lv(ch)}), 32'({3'b000, 8'h00, v[7:0]}));
      do_wr(ch, v[15:8]);
      chk("R4 random load", 32'({load_stb, lv(ch)}), 32'({3'(1 << ch), v}));
      l1 = 16'($urandom);
      l2 = 16'($urandom);
      set_live(ch, l1);
      do_wr(3, cfg_byte(ch, 0, 0, 0));
      set_live(ch, l2);
      do_rd(ch, b); chk("R6 random frozen low", 32'(b), 32'(l1[7:0]));
      do_rd(ch, b); chk("R6 random frozen high", 32'(b), 32'(l1[15:8]));
      do_rd(ch, b); chk("R8 random live low", 32'(b), 32'(l2[7:0]));
      do_rd(ch, b); chk("R8 random live high", 32'(b), 32'(l2[15:8]));
    end

    finish_run();
  end

endmodule